// File: doc/BRIEF.md
# Maskable Interrupt Latch Controller

This block arbitrates interrupt requests for a small 8-bit processor. Every hardware interrupt source, numbered 2 through 29, owns a pending flag. A one-cycle pulse on that source's request line sets the flag. A second 32-bit register holds one enable flag per source, and its bit 0 serves as a global gate for all maskable sources. Sources 2 and 3 cannot be masked: the enable register has no effect on them.

The processor reads and writes both registers through a byte-wide special-function-register port. Software may clear pending flags but can never set one. The block always offers the lowest-numbered eligible source on `reqIndex`, qualified by `reqValid`. When the core accepts that request with `acceptStb`, three things happen in the same cycle: the chosen pending flag is cleared, the global gate is pushed onto a four-entry LIFO, and the gate is cleared. A `returnStb` pops the LIFO back into the gate. Because the LIFO holds four entries, nested service routines restore the gate correctly.

Top module: `irq_latch_ctrl`

## Requirements
- R1: A pulse on `irqIn[i]` for 2 ≤ i ≤ 29 sets pending bit i at the next clock edge. Pulses on bits 0, 1, 30 and 31 are ignored, and those pending bits always read 0.
- R2: The pending register is read as bytes at these addresses: 0x3C holds bits 7:0, 0x3D bits 15:8, 0x2E bits 23:16 and 0x2F bits 31:24. Every address that is not mapped reads 0x00.
- R3: A write to a pending byte clears each bit written as 0. A bit written as 1 keeps its value, so software can never set a pending bit.
- R4: The enable register is read and written as bytes at these addresses: 0x3A holds bits 7:0, 0x3B bits 15:8, 0x2C bits 23:16 and 0x2D bits 31:24. Bit 0 of 0x3A is the global gate. Every bit reads back the value last written.
- R5: A maskable source (index 4 to 29) is eligible only while it is pending, its enable bit is 1 and the global gate is 1.
- R6: Sources 2 and 3 are eligible whenever they are pending, whatever the enable register holds. Software writes of 0 to their pending bits are ignored.
- R7: `reqValid` is 1 when at least one source is eligible. `reqIndex` then gives the lowest eligible index, so sources 2 and 3 always win over maskable sources.
- R8: `acceptStb` while `reqValid` is 1 clears the pending bit named by `reqIndex` at the next edge. `acceptStb` while `reqValid` is 0 has no effect.
- R9: An accepted request pushes the current global gate onto the LIFO and clears the gate.
- R10: `returnStb` pops the most recently saved gate value back into the gate. The LIFO holds 4 entries, and a fifth push overwrites the oldest entry without any indication.
- R11: A hardware request on a pending bit in the same cycle as a software clear or an accept clear of that bit leaves the bit set.
- R12: Reset clears every pending bit, every enable bit, the global gate and the LIFO.
- R13: In the same cycle, an accept takes priority over a software write of the global gate, and over a return strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| irqIn | input | 32 | Per-source request pulses |
| sfrAddr | input | 8 | Register byte address |
| sfrWrEn | input | 1 | Write strobe for the register port |
| sfrWrData | input | 8 | Write data |
| sfrRdData | output | 8 | Combinational read data for `sfrAddr` |
| acceptStb | input | 1 | Core accepts the offered request |
| returnStb | input | 1 | Core returns from a service routine |
| reqValid | output | 1 | An eligible request is offered |
| reqIndex | output | 5 | Index of the offered source |

## Verification
The bench writes all-ones to a pending byte. A design that treats the write as a plain store would set pending bits out of nothing. It also clears a byte that contains a non-maskable bit, which a design that forgets to protect sources 2 and 3 would lose. The bench raises a request in the same cycle as a software clear, and again in the same cycle as an accept. A design that lets either clear win drops a live request. It nests two accepts around a return pair and checks the gate value after each pop. It also accepts while software writes the gate. This exposes a flat save register or a wrong priority between the strobes, because either one leaves the gate open during service.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 4;
  localparam int REG_BITS  = BYTE_W * NUM_BYTES;
  localparam int IDX_W     = $clog2(REG_BITS);

  typedef struct packed {
    logic [NUM_BYTES-1:0] pendByteWr;
    logic [NUM_BYTES-1:0] enByteWr;
    logic [BYTE_W-1:0]    wrData;
    logic                 acceptGo;
    logic [IDX_W-1:0]     acceptIdx;
    logic                 returnGo;
  } strobe_t;

  function automatic logic [REG_BITS-1:0] srcMask(input int lo, input int hi);
    logic [REG_BITS-1:0] m;
    m = '0;
    for (int i = 0; i < REG_BITS; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_latch_ctl.sv
module irq_latch_ctl
  import irq_latch_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SRC_LO = 2,
  parameter int SRC_HI = 29,
  parameter int NMI_HI = 3,
  parameter logic [ADDR_W-1:0] PEND_ADDR0 = 8'h3C,
  parameter logic [ADDR_W-1:0] PEND_ADDR1 = 8'h3D,
  parameter logic [ADDR_W-1:0] PEND_ADDR2 = 8'h2E,
  parameter logic [ADDR_W-1:0] PEND_ADDR3 = 8'h2F,
  parameter logic [ADDR_W-1:0] EN_ADDR0   = 8'h3A,
  parameter logic [ADDR_W-1:0] EN_ADDR1   = 8'h3B,
  parameter logic [ADDR_W-1:0] EN_ADDR2   = 8'h2C,
  parameter logic [ADDR_W-1:0] EN_ADDR3   = 8'h2D
) (
  input  logic [ADDR_W-1:0]   sfrAddr,
  input  logic                sfrWrEn,
  input  logic [BYTE_W-1:0]   sfrWrData,
  input  logic                acceptStb,
  input  logic                returnStb,
  input  logic [REG_BITS-1:0] pendVec,
  input  logic [REG_BITS-1:0] enVec,
  output logic                reqValid,
  output logic [IDX_W-1:0]    reqIndex,
  output logic [BYTE_W-1:0]   sfrRdData,
  output strobe_t             strobes
);
  localparam logic [REG_BITS-1:0] SRC_MASK = srcMask(SRC_LO, SRC_HI);
  localparam logic [ADDR_W-1:0] PEND_MAP [NUM_BYTES] =
    '{PEND_ADDR0, PEND_ADDR1, PEND_ADDR2, PEND_ADDR3};
  localparam logic [ADDR_W-1:0] EN_MAP [NUM_BYTES] =
    '{EN_ADDR0, EN_ADDR1, EN_ADDR2, EN_ADDR3};

  logic [NUM_BYTES-1:0] pendHit, enHit;
  logic [REG_BITS-1:0]  eligible;
  logic                 pickValid;
  logic [IDX_W-1:0]     pickIdx;

  // Byte address decode, one comparator per mapped byte
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_decode
    assign pendHit[b] = (sfrAddr == PEND_MAP[b]);
    assign enHit[b]   = (sfrAddr == EN_MAP[b]);
  end

  // Eligibility: non-maskable bypass, maskable gated by master and own enable
  always_comb begin
    for (int i = 0; i < REG_BITS; i++) begin
      eligible[i] = SRC_MASK[i] && pendVec[i] &&
                    ((i <= NMI_HI) || (enVec[0] && enVec[i]));
    end
  end

  // Lowest index wins
  always_comb begin
    pickValid = 1'b0;
    pickIdx   = '0;
    for (int i = REG_BITS - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        pickValid = 1'b1;
        pickIdx   = IDX_W'(i);
      end
    end
  end

  assign reqValid = pickValid;
  assign reqIndex = pickIdx;

  // Read mux
  always_comb begin
    sfrRdData = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (pendHit[b]) sfrRdData = sfrRdData | pendVec[b*BYTE_W +: BYTE_W];
      if (enHit[b])   sfrRdData = sfrRdData | enVec[b*BYTE_W +: BYTE_W];
    end
  end

  // Strobes towards the datapath
  always_comb begin
    strobes.pendByteWr = pendHit & {NUM_BYTES{sfrWrEn}};
    strobes.enByteWr   = enHit & {NUM_BYTES{sfrWrEn}};
    strobes.wrData     = sfrWrData;
    strobes.acceptGo   = acceptStb && pickValid;
    strobes.acceptIdx  = pickIdx;
    strobes.returnGo   = returnStb && !(acceptStb && pickValid);
  end
endmodule

// File: rtl/irq_latch_dp.sv
module irq_latch_dp
  import irq_latch_pkg::*;
#(
  parameter int SRC_LO      = 2,
  parameter int SRC_HI      = 29,
  parameter int NMI_HI      = 3,
  parameter int STACK_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [REG_BITS-1:0] irqIn,
  input  strobe_t             strobes,
  output logic [REG_BITS-1:0] pendVec,
  output logic [REG_BITS-1:0] enVec,
  output logic                masterEn
);
  localparam int PTR_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
  localparam logic [REG_BITS-1:0] SRC_MASK = srcMask(SRC_LO, SRC_HI);

  logic unusedIrqBits;
  assign unusedIrqBits = ^(irqIn & ~SRC_MASK);

  // Pending latches: hardware set beats any clear
  for (genvar i = 0; i < REG_BITS; i++) begin : g_pend
    if (i >= SRC_LO && i <= SRC_HI) begin : g_src
      localparam bit IS_NMI = (i <= NMI_HI);
      logic bitQ, swClr, accClr;
      assign swClr  = strobes.pendByteWr[i / BYTE_W] &&
                      !strobes.wrData[i % BYTE_W] && !IS_NMI;
      assign accClr = strobes.acceptGo && (strobes.acceptIdx == IDX_W'(i));
      always_ff @(posedge clk) begin
        if (!rstN)                 bitQ <= 1'b0;
        else if (irqIn[i])         bitQ <= 1'b1;
        else if (swClr || accClr)  bitQ <= 1'b0;
      end
      assign pendVec[i] = bitQ;
    end else begin : g_none
      assign pendVec[i] = 1'b0;
    end
  end

  // Individual enables (bit 0 is the master gate, kept separately)
  logic [REG_BITS-1:1] enQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ <= '0;
    end else begin
      for (int k = 1; k < REG_BITS; k++) begin
        if (strobes.enByteWr[k / BYTE_W]) enQ[k] <= strobes.wrData[k % BYTE_W];
      end
    end
  end

  // Master gate with save/restore LIFO
  logic [STACK_DEPTH-1:0] stackQ;
  logic [PTR_W-1:0]       ptrQ;
  logic                   masterQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterQ <= 1'b0;
      stackQ  <= '0;
      ptrQ    <= '0;
    end else if (strobes.acceptGo) begin
      stackQ[ptrQ] <= masterQ;
      ptrQ         <= ptrQ + PTR_ONE;
      masterQ      <= 1'b0;
    end else if (strobes.returnGo) begin
      ptrQ    <= ptrQ - PTR_ONE;
      masterQ <= stackQ[ptrQ - PTR_ONE];
    end else if (strobes.enByteWr[0]) begin
      masterQ <= strobes.wrData[0];
    end
  end

  assign enVec    = {enQ, masterQ};
  assign masterEn = masterQ;
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SRC_LO      = 2,
  parameter int SRC_HI      = 29,
  parameter int NMI_HI      = 3,
  parameter int STACK_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [REG_BITS-1:0] irqIn,
  input  logic [ADDR_W-1:0]   sfrAddr,
  input  logic                sfrWrEn,
  input  logic [BYTE_W-1:0]   sfrWrData,
  output logic [BYTE_W-1:0]   sfrRdData,
  input  logic                acceptStb,
  input  logic                returnStb,
  output logic                reqValid,
  output logic [IDX_W-1:0]    reqIndex
);
  strobe_t             strobes;
  logic [REG_BITS-1:0] pendVec, enVec;
  logic                masterEn;

  irq_latch_ctl #(
    .ADDR_W(ADDR_W), .SRC_LO(SRC_LO), .SRC_HI(SRC_HI), .NMI_HI(NMI_HI)
  ) u_ctl (
    .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .sfrWrData(sfrWrData),
    .acceptStb(acceptStb), .returnStb(returnStb),
    .pendVec(pendVec), .enVec(enVec),
    .reqValid(reqValid), .reqIndex(reqIndex),
    .sfrRdData(sfrRdData), .strobes(strobes)
  );

  irq_latch_dp #(
    .SRC_LO(SRC_LO), .SRC_HI(SRC_HI), .NMI_HI(NMI_HI), .STACK_DEPTH(STACK_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strobes(strobes),
    .pendVec(pendVec), .enVec(enVec), .masterEn(masterEn)
  );
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk
  import irq_latch_pkg::*;
#(
  parameter int SRC_LO = 2,
  parameter int SRC_HI = 29,
  parameter int NMI_HI = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [REG_BITS-1:0] irqIn,
  input logic                acceptStb,
  input logic                reqValid,
  input logic [IDX_W-1:0]    reqIndex,
  input logic [REG_BITS-1:0] pendVec,
  input logic                masterEn
);
  localparam logic [REG_BITS-1:0] SRC_MASK = srcMask(SRC_LO, SRC_HI);

  assert_reset_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pendVec == '0 && !masterEn));

  assert_req_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
    |(irqIn & SRC_MASK) |=>
      ((pendVec & $past(irqIn & SRC_MASK)) == $past(irqIn & SRC_MASK)));

  // R3: nothing but a request can raise a pending bit
  assert_no_sw_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & ~$past(pendVec) & ~$past(irqIn)) == '0);

  assert_mask_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (int'(reqIndex) > NMI_HI)) |-> masterEn);

  assert_nmi_bypass_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|pendVec[NMI_HI:SRC_LO]) |-> (reqValid && int'(reqIndex) <= NMI_HI));

  assert_pick_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (pendVec[reqIndex] && SRC_MASK[reqIndex]));

  assert_accept_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (acceptStb && reqValid && !irqIn[reqIndex]) |=> !pendVec[$past(reqIndex)]);

  assert_accept_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (acceptStb && reqValid) |=> !masterEn);
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(
  .SRC_LO(SRC_LO), .SRC_HI(SRC_HI), .NMI_HI(NMI_HI)
) u_chk (
  .clk(clk), .rstN(rstN), .irqIn(irqIn), .acceptStb(acceptStb),
  .reqValid(reqValid), .reqIndex(reqIndex), .pendVec(pendVec),
  .masterEn(masterEn)
);

// File: tb/irq_latch_ctrl_bench.sv
`timescale 1ns/1ps
module irq_latch_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '0;
  logic [7:0]  sfrAddr = '0;
  logic        sfrWrEn = 1'b0;
  logic [7:0]  sfrWrData = '0;
  logic [7:0]  sfrRdData;
  logic        acceptStb = 1'b0;
  logic        returnStb = 1'b0;
  logic        reqValid;
  logic [4:0]  reqIndex;

  always #4 clk = ~clk;

  irq_latch_ctrl u_irq_latch_ctrl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .sfrAddr(sfrAddr),
    .sfrWrEn(sfrWrEn), .sfrWrData(sfrWrData), .sfrRdData(sfrRdData),
    .acceptStb(acceptStb), .returnStb(returnStb),
    .reqValid(reqValid), .reqIndex(reqIndex)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  int    kindQ[$];
  int    expQ[$];
  string tagQ[$];

  // Monitor: pops one expected item per cycle and compares after the drive
  always begin
    @(negedge clk);
    #2;
    if (kindQ.size() > 0) begin
      int k, e, got;
      string t;
      k = kindQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      got = (k == 0) ? int'(sfrRdData) : (reqValid ? 32 + int'(reqIndex) : 0);
      checks++;
      if (got !== e) begin
        errors++;
        $display("FAIL %s: actual=0x%0h expected=0x%0h", t, got, e);
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic step(input logic [31:0] irq, input bit wr, input logic [7:0] a,
                      input logic [7:0] d, input bit acc, input bit ret);
    irqIn = irq; sfrWrEn = wr; sfrAddr = a; sfrWrData = d;
    acceptStb = acc; returnStb = ret;
    cyc();
    irqIn = '0; sfrWrEn = 0; acceptStb = 0; returnStb = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step('0, 1, a, d, 0, 0);
  endtask

  task automatic pulse(input int idx);
    step(32'h1 << idx, 0, sfrAddr, 8'h00, 0, 0);
  endtask

  task automatic checkRd(input logic [7:0] a, input int e, input string t);
    sfrAddr = a;
    kindQ.push_back(0); expQ.push_back(e); tagQ.push_back(t);
    cyc();
  endtask

  task automatic checkReq(input bit v, input int idx, input string t);
    kindQ.push_back(1); expQ.push_back(v ? 32 + idx : 0); tagQ.push_back(t);
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    // R12 reset state
    checkRd(8'h3C, 8'h00, "R12 pend byte0");
    checkRd(8'h2F, 8'h00, "R12 pend byte3");
    checkRd(8'h3A, 8'h00, "R12 enable byte0");
    checkReq(0, 0, "R12 no request");
    // R1 / R2 set and read map
    step(32'h0000_0220, 0, 8'h00, 8'h00, 0, 0);
    checkRd(8'h3C, 8'h20, "R1 bit5 in 0x3C");
    checkRd(8'h3D, 8'h02, "R2 bit9 in 0x3D");
    checkReq(0, 0, "R5 gate closed");
    step(32'hC000_0003, 0, 8'h00, 8'h00, 0, 0);
    checkRd(8'h3C, 8'h20, "R1 bits 0,1 ignored");
    checkRd(8'h2F, 8'h00, "R1 bits 30,31 ignored");
    // R3 software cannot set, can clear
    wr(8'h3D, 8'hFF);
    checkRd(8'h3D, 8'h02, "R3 ones keep value");
    wr(8'h3D, 8'h00);
    checkRd(8'h3D, 8'h00, "R3 zero clears");
    // R4 enable map
    wr(8'h3B, 8'hA5); wr(8'h2C, 8'h3C); wr(8'h2D, 8'hC3); wr(8'h3A, 8'h20);
    checkRd(8'h3B, 8'hA5, "R4 0x3B readback");
    checkRd(8'h2C, 8'h3C, "R4 0x2C readback");
    checkRd(8'h2D, 8'hC3, "R4 0x2D readback");
    checkRd(8'h3A, 8'h20, "R4 0x3A readback");
    checkReq(0, 0, "R5 enabled but gate 0");
    wr(8'h3A, 8'h21);
    checkReq(1, 5, "R5 gate open offers 5");
    pulse(8);
    checkReq(1, 5, "R7 lowest of 5 and 8");
    // R6 non-maskable
    pulse(3);
    checkReq(1, 3, "R6 source 3 wins");
    wr(8'h3C, 8'h00);
    checkRd(8'h3C, 8'h08, "R6 clear of bit3 ignored");
    // R8 / R9 accept
    step('0, 0, 8'h00, 8'h00, 1, 0);
    checkRd(8'h3C, 8'h00, "R8 accepted bit3 cleared");
    checkRd(8'h3A, 8'h20, "R9 gate cleared");
    checkReq(0, 0, "R5 bit8 masked in service");
    pulse(2);
    checkReq(1, 2, "R6 source 2 while gate 0");
    step('0, 0, 8'h00, 8'h00, 1, 0);
    checkRd(8'h3C, 8'h00, "R8 bit2 cleared");
    // R10 nested restore
    step('0, 0, 8'h00, 8'h00, 0, 1);
    checkRd(8'h3A, 8'h20, "R10 inner pop gives 0");
    step('0, 0, 8'h00, 8'h00, 0, 1);
    checkRd(8'h3A, 8'h21, "R10 outer pop gives 1");
    checkReq(1, 8, "R7 source 8 offered");
    // R11 set beats clear
    step(32'h100, 1, 8'h3D, 8'h00, 0, 0);
    checkRd(8'h3D, 8'h01, "R11 set beats sw clear");
    step(32'h100, 0, 8'h00, 8'h00, 1, 0);
    checkRd(8'h3D, 8'h01, "R11 set beats accept clear");
    checkRd(8'h3A, 8'h20, "R9 gate cleared again");
    step('0, 0, 8'h00, 8'h00, 0, 1);
    step('0, 0, 8'h00, 8'h00, 1, 0);
    checkRd(8'h3D, 8'h00, "R8 bit8 cleared");
    step('0, 0, 8'h00, 8'h00, 0, 1);
    checkRd(8'h3A, 8'h21, "R10 gate restored");
    // R8 accept with nothing offered
    checkReq(0, 0, "R8 nothing pending");
    step('0, 0, 8'h00, 8'h00, 1, 0);
    checkRd(8'h3A, 8'h21, "R8 idle accept ignored");
    // R13 accept beats software write of gate
    pulse(10);
    checkReq(1, 10, "R7 source 10 offered");
    step('0, 1, 8'h3A, 8'h21, 1, 0);
    checkRd(8'h3A, 8'h20, "R13 accept beats gate write");
    checkRd(8'h3D, 8'h00, "R8 bit10 cleared");
    step('0, 0, 8'h00, 8'h00, 0, 1);
    checkRd(8'h3A, 8'h21, "R10 gate back after R13");
    // R2 upper bytes and unmapped
    pulse(20);
    checkRd(8'h2E, 8'h10, "R2 bit20 in 0x2E");
    checkReq(1, 20, "R5 source 20 enabled");
    pulse(29);
    checkRd(8'h2F, 8'h20, "R2 bit29 in 0x2F");
    checkRd(8'h50, 8'h00, "R2 unmapped reads 0");
    // R12 reset mid-run
    rstN = 1'b0; cyc(); rstN = 1'b1;
    checkRd(8'h2E, 8'h00, "R12 pend cleared");
    checkRd(8'h3A, 8'h00, "R12 gate cleared");
    checkRd(8'h3B, 8'h00, "R12 enables cleared");
    repeat (3) cyc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule